// File: doc/BRIEF.md
# Charge Safety Timer with Slowdown and USB Time Cap

This block watches how long a battery charge cycle has been running and flags a timer fault when a programmed limit is reached. Time is measured in minute ticks from an internal prescaler. A two-bit field selects the fast-charge limit. A fixed two-hour limit takes over while the battery is below its low threshold. When the charge current is known to be reduced by regulation or by a forced reduction, the timer accepts only every other tick, so the limit stretches to twice its wall-clock length. A separate counter caps the total charge time from a 100 mA host port in default mode and then requests the high-impedance input state.

The timer is restarted by any of four events: a new charge cycle begins, the charge-enable pin goes high, then low, then high again, the charge-configuration field is written from 00 to 01, or the timer-enable bit goes from 0 to 1. While no charge is in progress the count is held. A fault stays latched until a restart. Clearing the timer-enable bit removes the fault and stops the count.

The control state machine has four states. OFF means the timer is disabled. HOLD means it is enabled but no charge is in progress. RUN means it is counting. EXPIRED means the fault is latched. The transitions are:

- any state to OFF when the enable bit is low;
- any state to RUN or HOLD, by charging status, on a restart;
- OFF or HOLD to RUN when charging starts;
- RUN to HOLD when charging stops;
- RUN to EXPIRED when the count reaches the limit.

EXPIRED has no exit other than a restart or the disable.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset, tmr_fault is 0, fault_code is 00, hiz_req is 0 and irq is 0.
- R2: With bat_low=0, fc_limit_sel selects the limit: 00 gives 300 minute ticks, 01 gives 480, 10 gives 720 and 11 gives 1200 (5, 8, 12 and 20 hours).
- R3: While bat_low=1, the limit is 120 minute ticks (2 hours), whatever fc_limit_sel holds.
- R4: When slow_en=1 and any of in_vreg, in_ireg, therm_reg or force_reduced is 1, only every other tick is counted, so the limit takes twice as long. With slow_en=0 the count runs at full rate.
- R5: While charging=0 the count does not advance.
- R6: When the count reaches the limit, tmr_fault goes to 1 and fault_code goes to 11, with a one-cycle irq pulse. Both stay set until a restart or until tmr_en=0.
- R7: While tmr_en=0 the timer neither counts nor faults.
- R8: A cycle_start pulse, or tmr_en rising from 0 to 1, clears the fault and restarts the count from zero.
- R9: The timer restarts on a rising edge of ce_pin only when that edge follows a high level and then a low level seen since reset. A first rise from the reset-time low level does not restart the timer.
- R10: A write (chg_cfg_wr=1) of 01 to chg_cfg restarts the timer only when the previously written value was 00; the value is 01 after reset.
- R11: While usb100_dflt=1, charging time is capped at 45 minute ticks counted at full rate. At the cap, hiz_req goes to 1 with an irq pulse. hiz_req drops when usb100_dflt goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| charging | input | 1 | Charge in progress |
| cycle_start | input | 1 | Pulse: a new charge cycle begins |
| bat_low | input | 1 | Battery below the low threshold |
| fc_limit_sel | input | 2 | Fast-charge limit select |
| tmr_en | input | 1 | Safety timer enable bit |
| slow_en | input | 1 | Half-rate enable bit |
| in_vreg | input | 1 | Input voltage regulation active |
| in_ireg | input | 1 | Input current regulation active |
| therm_reg | input | 1 | Thermal regulation active |
| force_reduced | input | 1 | Forced reduced-current mode |
| ce_pin | input | 1 | Charge-enable pin level |
| chg_cfg_wr | input | 1 | Write strobe for the charge-config field |
| chg_cfg | input | 2 | Value written to the charge-config field |
| usb100_dflt | input | 1 | Default mode on a 100 mA host source |
| tmr_fault | output | 1 | Safety timer expired |
| fault_code | output | 2 | Charge fault code (11 on expiry) |
| hiz_req | output | 1 | Stop converter, enter high impedance |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench places its checks a couple of ticks either side of each limit. A wrong limit code, a limit that misses the low-battery override, or a slowdown that ignores one of the four flags therefore shows up as a fault that comes too early or never comes. The restart sequences are checked against their near misses. These are a first rise of the enable pin, a rewrite of 01 over 01, and a config change with no write strobe. A detector that is too eager would clear a latched fault that must stay set. The hold check leaves the count idle for longer than the limit and then resumes it. A design that kept counting while idle would fault during the idle period or too early after charging resumes. The USB cap is checked for its assertion and for its release when the source is removed.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RUN     = 2'd2,
        ST_EXPIRED = 2'd3
    } cst_state_e;

    localparam logic [1:0] FAULT_NONE  = 2'b00;
    localparam logic [1:0] FAULT_TIMER = 2'b11;
endpackage

// File: rtl/cst_tick_gen.sv
module cst_tick_gen #(
    parameter int unsigned CLK_PER_MIN = 6000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_PER_MIN <= 1) begin : g_direct
            assign tick = rst_n;
        end else begin : g_div
            localparam int unsigned PW = $clog2(CLK_PER_MIN);
            localparam logic [PW-1:0] LAST = PW'(CLK_PER_MIN - 1);
            logic [PW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              div_q <= '0;
                else if (div_q == LAST)  div_q <= '0;
                else                     div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/cst_rate_gate.sv
module cst_rate_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic slow_en,
    input  logic in_vreg,
    input  logic in_ireg,
    input  logic therm_reg,
    input  logic force_reduced,
    output logic acc_tick
);
    logic slow;
    logic half_q;

    assign slow = slow_en && (in_vreg || in_ireg || therm_reg || force_reduced);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         half_q <= 1'b0;
        else if (!slow)     half_q <= 1'b0;
        else if (tick)      half_q <= ~half_q;
    end

    assign acc_tick = tick && (!slow || half_q);
endmodule

// File: rtl/cst_restart_detect.sv
module cst_restart_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cycle_start,
    input  logic       ce_pin,
    input  logic       chg_cfg_wr,
    input  logic [1:0] chg_cfg,
    input  logic       tmr_en,
    output logic       restart
);
    typedef enum logic [1:0] {
        CE_IDLE  = 2'd0,
        CE_HIGH  = 2'd1,
        CE_LOW   = 2'd2
    } ce_seq_e;

    ce_seq_e    ce_st;
    ce_seq_e    ce_nxt;
    logic       ce_q;
    logic [1:0] cfg_shadow;
    logic       en_q;
    logic       ce_hit;
    logic       cfg_hit;
    logic       en_hit;

    always_comb begin
        ce_nxt = ce_st;
        unique case (ce_st)
            CE_IDLE: if (ce_pin)  ce_nxt = CE_HIGH;
            CE_HIGH: if (!ce_pin) ce_nxt = CE_LOW;
            CE_LOW:  if (ce_pin)  ce_nxt = CE_HIGH;
            default:              ce_nxt = CE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_st      <= CE_IDLE;
            ce_q       <= 1'b0;
            cfg_shadow <= 2'b01;
            en_q       <= 1'b1;
        end else begin
            ce_st <= ce_nxt;
            ce_q  <= ce_pin;
            en_q  <= tmr_en;
            if (chg_cfg_wr) cfg_shadow <= chg_cfg;
        end
    end

    assign ce_hit  = (ce_st == CE_LOW) && ce_pin && !ce_q;
    assign cfg_hit = chg_cfg_wr && (chg_cfg == 2'b01) && (cfg_shadow == 2'b00);
    assign en_hit  = tmr_en && !en_q;
    assign restart = cycle_start || ce_hit || cfg_hit || en_hit;
endmodule

// File: rtl/cst_usb_cap.sv
module cst_usb_cap #(
    parameter int unsigned CAP_MIN = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic charging,
    input  logic usb100_dflt,
    input  logic restart,
    output logic hiz_req,
    output logic hiz_set
);
    localparam int unsigned UW = $clog2(CAP_MIN + 1);
    localparam logic [UW-1:0] LAST = UW'(CAP_MIN - 1);

    logic [UW-1:0] ucnt_q;
    logic          hiz_q;
    logic          step;

    assign step    = usb100_dflt && !restart && !hiz_q && charging && tick;
    assign hiz_set = step && (ucnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ucnt_q <= '0;
            hiz_q  <= 1'b0;
        end else if (!usb100_dflt || restart) begin
            ucnt_q <= '0;
            hiz_q  <= 1'b0;
        end else if (step) begin
            ucnt_q <= ucnt_q + 1'b1;
            if (hiz_set) hiz_q <= 1'b1;
        end
    end

    assign hiz_req = hiz_q;
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
    import cst_pkg::*;
#(
    parameter int unsigned CLK_PER_MIN  = 6000,
    parameter int unsigned MIN_PER_HOUR = 60,
    parameter int unsigned USB_CAP_MIN  = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       charging,
    input  logic       cycle_start,
    input  logic       bat_low,
    input  logic [1:0] fc_limit_sel,
    input  logic       tmr_en,
    input  logic       slow_en,
    input  logic       in_vreg,
    input  logic       in_ireg,
    input  logic       therm_reg,
    input  logic       force_reduced,
    input  logic       ce_pin,
    input  logic       chg_cfg_wr,
    input  logic [1:0] chg_cfg,
    input  logic       usb100_dflt,
    output logic       tmr_fault,
    output logic [1:0] fault_code,
    output logic       hiz_req,
    output logic       irq
);
    localparam int unsigned LIM_2H  = 2  * MIN_PER_HOUR;
    localparam int unsigned LIM_5H  = 5  * MIN_PER_HOUR;
    localparam int unsigned LIM_8H  = 8  * MIN_PER_HOUR;
    localparam int unsigned LIM_12H = 12 * MIN_PER_HOUR;
    localparam int unsigned LIM_20H = 20 * MIN_PER_HOUR;
    localparam int unsigned CNT_W   = $clog2(LIM_20H + 1);

    logic             tick;
    logic             acc_tick;
    logic             restart;
    logic             hiz_set;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    cst_state_e       state;
    cst_state_e       nxt;

    cst_tick_gen #(.CLK_PER_MIN(CLK_PER_MIN)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    cst_rate_gate u_rate (
        .clk(clk), .rst_n(rst_n), .tick(tick), .slow_en(slow_en),
        .in_vreg(in_vreg), .in_ireg(in_ireg), .therm_reg(therm_reg),
        .force_reduced(force_reduced), .acc_tick(acc_tick)
    );

    cst_restart_detect u_rst (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ce_pin(ce_pin),
        .chg_cfg_wr(chg_cfg_wr), .chg_cfg(chg_cfg), .tmr_en(tmr_en),
        .restart(restart)
    );

    cst_usb_cap #(.CAP_MIN(USB_CAP_MIN)) u_usb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .charging(charging),
        .usb100_dflt(usb100_dflt), .restart(restart),
        .hiz_req(hiz_req), .hiz_set(hiz_set)
    );

    always_comb begin
        if (bat_low) begin
            limit = CNT_W'(LIM_2H);
        end else begin
            unique case (fc_limit_sel)
                2'b00:   limit = CNT_W'(LIM_5H);
                2'b01:   limit = CNT_W'(LIM_8H);
                2'b10:   limit = CNT_W'(LIM_12H);
                default: limit = CNT_W'(LIM_20H);
            endcase
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!tmr_en) begin
            nxt = ST_OFF;
        end else if (restart) begin
            nxt = charging ? ST_RUN : ST_HOLD;
        end else begin
            unique case (state)
                ST_OFF:     nxt = charging ? ST_RUN : ST_HOLD;
                ST_HOLD:    nxt = charging ? ST_RUN : ST_HOLD;
                ST_RUN: begin
                    if (cnt_q >= limit) nxt = ST_EXPIRED;
                    else if (!charging) nxt = ST_HOLD;
                    else                nxt = ST_RUN;
                end
                ST_EXPIRED: nxt = ST_EXPIRED;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    // state register, count and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            state <= nxt;
            irq_q <= ((nxt == ST_EXPIRED) && (state != ST_EXPIRED)) || hiz_set;
            if (!tmr_en || restart)
                cnt_q <= '0;
            else if ((state == ST_RUN) && charging && acc_tick && (cnt_q < limit))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tmr_fault  = (state == ST_EXPIRED);
        fault_code = (state == ST_EXPIRED) ? FAULT_TIMER : FAULT_NONE;
        irq        = irq_q;
    end
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
    parameter int unsigned CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             charging,
    input logic             cycle_start,
    input logic             tmr_en,
    input logic             usb100_dflt,
    input logic             restart,
    input logic [CNT_W-1:0] cnt_q,
    input logic             tmr_fault,
    input logic             hiz_req,
    input logic             irq
);
    p_irq_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_fault) |-> irq);

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_fault && tmr_en && !restart) |=> tmr_fault);

    p_off_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> !tmr_fault);

    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !tmr_fault);

    p_hold_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!charging && tmr_en && !restart) |=> $stable(cnt_q));

    p_hiz_needs_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !usb100_dflt |=> !hiz_req);
endmodule

bind chg_safety_timer cst_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .charging(charging), .cycle_start(cycle_start),
    .tmr_en(tmr_en), .usb100_dflt(usb100_dflt), .restart(restart),
    .cnt_q(cnt_q), .tmr_fault(tmr_fault), .hiz_req(hiz_req), .irq(irq)
);

// File: tb/sim_chg_safety_timer.sv
`timescale 1ns/1ps
module sim_chg_safety_timer;
    localparam int unsigned CPM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic charging = 0, cycle_start = 0, bat_low = 0, tmr_en = 1, slow_en = 1;
    logic in_vreg = 0, in_ireg = 0, therm_reg = 0, force_reduced = 0;
    logic ce_pin = 0, chg_cfg_wr = 0, usb100_dflt = 0;
    logic [1:0] fc_limit_sel = 2'b01, chg_cfg = 2'b01;
    logic tmr_fault, hiz_req, irq;
    logic [1:0] fault_code;

    int checks = 0, failures = 0, irq_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chg_safety_timer #(.CLK_PER_MIN(CPM), .MIN_PER_HOUR(60), .USB_CAP_MIN(45)) u0 (
        .clk(clk), .rst_n(rst_n), .charging(charging), .cycle_start(cycle_start),
        .bat_low(bat_low), .fc_limit_sel(fc_limit_sel), .tmr_en(tmr_en),
        .slow_en(slow_en), .in_vreg(in_vreg), .in_ireg(in_ireg),
        .therm_reg(therm_reg), .force_reduced(force_reduced), .ce_pin(ce_pin),
        .chg_cfg_wr(chg_cfg_wr), .chg_cfg(chg_cfg), .usb100_dflt(usb100_dflt),
        .tmr_fault(tmr_fault), .fault_code(fault_code), .hiz_req(hiz_req), .irq(irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_min(input int n);
        repeat (n * CPM) @(negedge clk);
    endtask

    task automatic pulse_start();
        cycle_start = 1; @(negedge clk); cycle_start = 0;
    endtask

    task automatic limit_run(input string req, input int lim);
        pulse_start();
        wait_min(lim - 3);
        check({req, " before limit"}, tmr_fault, 0);
        wait_min(5);
        check({req, " after limit"}, tmr_fault, 1);
    endtask

    task automatic t_reset();
        check("R1 fault", tmr_fault, 0);
        check("R1 code", fault_code, 0);
        check("R1 hiz", hiz_req, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_default_8h();
        int irq0;
        charging = 1;
        irq0 = irq_seen;
        limit_run("R2 sel01", 480);
        check("R6 code", fault_code, 3);
        check("R6 irq pulse", irq_seen - irq0, 1);
        wait_min(20);
        check("R6 sticky", tmr_fault, 1);
        check("R6 single irq", irq_seen - irq0, 1);
    endtask

    task automatic t_codes();
        fc_limit_sel = 2'b00; limit_run("R2 sel00", 300);
        fc_limit_sel = 2'b10; limit_run("R2 sel10", 720);
        fc_limit_sel = 2'b11; limit_run("R2 sel11", 1200);
        pulse_start(); @(negedge clk);
        check("R8 cycle_start clears", tmr_fault, 0);
    endtask

    task automatic t_bat_low();
        bat_low = 1; fc_limit_sel = 2'b11;
        limit_run("R3 bat_low", 120);
    endtask

    task automatic t_slow();
        bat_low = 0; fc_limit_sel = 2'b00;
        in_ireg = 1;
        pulse_start();
        wait_min(596);
        check("R4 half rate early", tmr_fault, 0);
        wait_min(8);
        check("R4 half rate late", tmr_fault, 1);
        in_ireg = 0; force_reduced = 1;
        pulse_start(); wait_min(400);
        check("R4 forced reduced half rate", tmr_fault, 0);
        force_reduced = 0; therm_reg = 1; slow_en = 0;
        limit_run("R4 slow_en off", 300);
        therm_reg = 0; slow_en = 1;
    endtask

    task automatic t_hold();
        charging = 0; fc_limit_sel = 2'b00;
        pulse_start();
        wait_min(400);
        check("R5 hold no fault", tmr_fault, 0);
        charging = 1;
        wait_min(296);
        check("R5 resumes from held count", tmr_fault, 0);
        wait_min(8);
        check("R5 expires after resume", tmr_fault, 1);
    endtask

    task automatic t_enable();
        tmr_en = 0; @(negedge clk); @(negedge clk);
        check("R7 disable clears fault", tmr_fault, 0);
        wait_min(400);
        check("R7 no fault while off", tmr_fault, 0);
        tmr_en = 1;
        wait_min(297);
        check("R8 enable rise restarts early", tmr_fault, 0);
        wait_min(6);
        check("R8 enable rise restarts late", tmr_fault, 1);
    endtask

    task automatic t_ce();
        ce_pin = 1; @(negedge clk); @(negedge clk);
        check("R9 first rise no restart", tmr_fault, 1);
        ce_pin = 0; @(negedge clk); @(negedge clk);
        check("R9 fall no restart", tmr_fault, 1);
        ce_pin = 1; @(negedge clk); @(negedge clk);
        check("R9 high-low-high restarts", tmr_fault, 0);
        wait_min(303);
        check("R9 refault", tmr_fault, 1);
    endtask

    task automatic t_cfg();
        chg_cfg = 2'b01; chg_cfg_wr = 1; @(negedge clk); chg_cfg_wr = 0;
        @(negedge clk);
        check("R10 01 over 01 no restart", tmr_fault, 1);
        chg_cfg = 2'b00; chg_cfg_wr = 1; @(negedge clk); chg_cfg_wr = 0;
        @(negedge clk);
        check("R10 write 00 no restart", tmr_fault, 1);
        chg_cfg = 2'b01; @(negedge clk); @(negedge clk);
        check("R10 no strobe no restart", tmr_fault, 1);
        chg_cfg_wr = 1; @(negedge clk); chg_cfg_wr = 0;
        @(negedge clk);
        check("R10 00 to 01 restarts", tmr_fault, 0);
    endtask

    task automatic t_usb();
        int irq0;
        fc_limit_sel = 2'b11;
        pulse_start();
        irq0 = irq_seen;
        usb100_dflt = 1;
        wait_min(43);
        check("R11 before cap", hiz_req, 0);
        wait_min(4);
        check("R11 at cap", hiz_req, 1);
        check("R11 irq", irq_seen - irq0, 1);
        usb100_dflt = 0; @(negedge clk); @(negedge clk);
        check("R11 source removed", hiz_req, 0);
    endtask

    initial begin
        #200000000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_default_8h();
        t_codes();
        t_bat_low();
        t_ce();
        t_cfg();
        bat_low = 0;
        t_slow();
        t_hold();
        t_enable();
        t_usb();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule